// File: doc/BRIEF.md
# Timer Channel Event Flag Unit

This block holds the event flags, interrupt enables and software event triggers for a timer with a single channel. The timer core feeds it an overflow strobe, a capture strobe and a compare strobe, along with a mode input. The mode input says whether the channel is capturing (input) or comparing (output). The block latches these events into sticky flags and raises one interrupt request while any enabled flag is pending.

Software reaches the block over a small register bus that has four word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Interrupt enable | read/write |
| 1 | Status | read, write 0 to clear |
| 2 | Event trigger | write only |
| 3 | Capture data | read only |

The capture-data value itself comes from outside the block. Reading it in input mode counts as acknowledging the channel flag.

When a second capture arrives before software has handled the first, a separate recapture flag records it. Software can also inject either kind of event by writing to the trigger register.

Top module: `chan_evt_flags`

## Requirements
- R1: A status read returns the overflow flag on bit 0, the channel flag on bit 1 and the recapture flag on bit 9, with every other bit 0. Read data of any address is registered: `bus_rdata` shows the value from before the read's clock edge, one cycle after `bus_rd`, and it holds between reads.
- R2: Writing a status word clears each flag whose bit (0, 1 or 9) is 0. A flag whose bit is written as 1 is unchanged.
- R3: With `mode_capture`=1, a capture strobe sets the channel flag and a compare strobe has no effect.
- R4: With `mode_capture`=0, a compare strobe sets the channel flag, a capture strobe has no effect, and a capture-data read does not clear the flag.
- R5: With `mode_capture`=1, a read of address 3 clears the channel flag. A read of address 3 returns `cap_value` in either mode.
- R6: A channel event in input mode while the channel flag is already 1 sets the recapture flag. The recapture flag clears only when status bit 9 is written as 0.
- R7: An overflow strobe sets the overflow flag. Only a status write clears it.
- R8: Enable register bit 0 enables the overflow interrupt and bit 1 enables the channel interrupt. Both read back at bits 1:0, and the upper bits read 0.
- R9: Writing the trigger register (address 2) with bit 0 set raises an overflow event, and with bit 1 set raises a channel event that behaves like a hardware one, including recapture. Bits written as 0 do nothing, and the register reads as 0.
- R10: When an event and a clear hit the same flag in one cycle, the flag ends up set.
- R11: `irq` is registered. It equals (overflow flag AND enable bit 0) OR (channel flag AND enable bit 1), taken from the cycle before.
- R12: A synchronous active-high `rst` clears all flags, the enables, `irq` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovf_strobe | input | 1 | Counter overflow pulse |
| cap_strobe | input | 1 | Channel capture pulse |
| cmp_strobe | input | 1 | Channel compare match pulse |
| mode_capture | input | 1 | 1 = channel in input (capture) mode, 0 = output (compare) mode |
| bus_addr | input | ADDR_W | Register address (0 enable, 1 status, 2 trigger, 3 capture data) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| cap_value | input | DATA_W | Captured counter value from the capture path |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=2. At that width a status read also exposes the reserved bits 2 to 8 and 10 to 15, so a stray bit there shows up in the compare. Random traffic mixes reads and writes that land in the same cycle as strobes, and toggles the mode while flags are pending. This reaches the case where a set and a clear collide and the case where a capture-data read clears the channel flag. Directed sequences then pin down recapture, trigger writes of zero, and the difference between the two modes on a capture-data read.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;
  localparam int unsigned A_ENABLE  = 0;
  localparam int unsigned A_STATUS  = 1;
  localparam int unsigned A_TRIGGER = 2;
  localparam int unsigned A_CAPDATA = 3;

  localparam int unsigned B_OVF  = 0;
  localparam int unsigned B_CH   = 1;
  localparam int unsigned B_RCAP = 9;

  localparam int unsigned MIN_DATA_W = B_RCAP + 1;

  typedef struct packed {
    logic ovf;
    logic ch;
    logic rcap;
  } flag_vec_t;
endpackage

// File: rtl/chan_evt_flag_bit.sv
module chan_evt_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/chan_evt_source.sv
module chan_evt_source (
  input  logic mode_capture,
  input  logic ovf_strobe,
  input  logic cap_strobe,
  input  logic cmp_strobe,
  input  logic sw_ovf,
  input  logic sw_ch,
  input  logic ch_now,
  output chan_evt_pkg::flag_vec_t evt_o
);
  logic hw_ch;
  always_comb begin
    hw_ch       = mode_capture ? cap_strobe : cmp_strobe;
    evt_o.ovf   = ovf_strobe | sw_ovf;
    evt_o.ch    = hw_ch | sw_ch;
    evt_o.rcap  = mode_capture & evt_o.ch & ch_now;
  end
endmodule

// File: rtl/chan_evt_regbus.sv
module chan_evt_regbus #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_capture,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cap_value,
  input  chan_evt_pkg::flag_vec_t flags_i,
  output logic [1:0]        en_o,
  output logic              sw_ovf,
  output logic              sw_ch,
  output chan_evt_pkg::flag_vec_t clr_o,
  output logic [DATA_W-1:0] bus_rdata
);
  import chan_evt_pkg::*;

  logic sel_en, sel_st, sel_tr, sel_cap;
  logic [DATA_W-1:0] status_word, rd_mux;

  always_comb begin
    sel_en  = bus_addr == ADDR_W'(A_ENABLE);
    sel_st  = bus_addr == ADDR_W'(A_STATUS);
    sel_tr  = bus_addr == ADDR_W'(A_TRIGGER);
    sel_cap = bus_addr == ADDR_W'(A_CAPDATA);
    sw_ovf  = bus_wr && sel_tr && bus_wdata[B_OVF];
    sw_ch   = bus_wr && sel_tr && bus_wdata[B_CH];
    clr_o.ovf  = bus_wr && sel_st && !bus_wdata[B_OVF];
    clr_o.ch   = (bus_wr && sel_st && !bus_wdata[B_CH]) ||
                 (mode_capture && bus_rd && sel_cap);
    clr_o.rcap = bus_wr && sel_st && !bus_wdata[B_RCAP];
    status_word         = '0;
    status_word[B_OVF]  = flags_i.ovf;
    status_word[B_CH]   = flags_i.ch;
    status_word[B_RCAP] = flags_i.rcap;
    rd_mux = '0;
    if (sel_en)       rd_mux[1:0] = en_o;
    else if (sel_st)  rd_mux = status_word;
    else if (sel_cap) rd_mux = cap_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && sel_en) en_o <= bus_wdata[1:0];
      if (bus_rd)           bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/chan_evt_flags.sv
module chan_evt_flags #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_strobe,
  input  logic              cap_strobe,
  input  logic              cmp_strobe,
  input  logic              mode_capture,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cap_value,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import chan_evt_pkg::*;

  localparam int N_FLAGS = $bits(flag_vec_t);

  if (DATA_W < int'(MIN_DATA_W)) begin : g_bad_width
    initial $error("DATA_W too narrow for status layout");
  end

  flag_vec_t flags, evt, clr;
  logic [1:0] en_q;
  logic sw_ovf, sw_ch;
  logic ovf_q, ch_q, rcap_q;

  chan_evt_source u_src (
    .mode_capture (mode_capture),
    .ovf_strobe   (ovf_strobe),
    .cap_strobe   (cap_strobe),
    .cmp_strobe   (cmp_strobe),
    .sw_ovf       (sw_ovf),
    .sw_ch        (sw_ch),
    .ch_now       (flags.ch),
    .evt_o        (evt)
  );

  chan_evt_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk          (clk),
    .rst          (rst),
    .mode_capture (mode_capture),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .cap_value    (cap_value),
    .flags_i      (flags),
    .en_o         (en_q),
    .sw_ovf       (sw_ovf),
    .sw_ch        (sw_ch),
    .clr_o        (clr),
    .bus_rdata    (bus_rdata)
  );

  logic [N_FLAGS-1:0] set_v, clr_v, q_v;
  assign set_v = evt;
  assign clr_v = clr;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    chan_evt_flag_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  assign flags  = q_v;
  assign ovf_q  = flags.ovf;
  assign ch_q   = flags.ch;
  assign rcap_q = flags.rcap;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (ovf_q & en_q[0]) | (ch_q & en_q[1]);
  end
endmodule

// File: rtl/chan_evt_flags_chk.sv
module chan_evt_flags_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ovf_strobe,
  input logic              cap_strobe,
  input logic              cmp_strobe,
  input logic              mode_capture,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              ovf_q,
  input logic              ch_q,
  input logic              rcap_q,
  input logic [1:0]        en_q
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !seen)
    irq == $past((ovf_q & en_q[0]) | (ch_q & en_q[1]))); // R11
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
    ovf_strobe |=> ovf_q); // R7
  AST_CAP_SETS: assert property (@(posedge clk) disable iff (rst)
    (mode_capture && cap_strobe) |=> ch_q); // R3
  AST_CMP_SETS: assert property (@(posedge clk) disable iff (rst)
    (!mode_capture && cmp_strobe) |=> ch_q); // R4
  AST_RECAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mode_capture && cap_strobe && ch_q) |=> rcap_q); // R6
  AST_OUT_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!mode_capture && ch_q && bus_rd && bus_addr == ADDR_W'(3) &&
     !(bus_wr && bus_addr == ADDR_W'(1))) |=> ch_q); // R4
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(2)) |=> bus_rdata == '0); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!irq && !ovf_q && !ch_q && !rcap_q && en_q == 2'b00)); // R12
endmodule

bind chan_evt_flags chan_evt_flags_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ovf_strobe(ovf_strobe), .cap_strobe(cap_strobe),
  .cmp_strobe(cmp_strobe), .mode_capture(mode_capture), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
  .ovf_q(ovf_q), .ch_q(ch_q), .rcap_q(rcap_q), .en_q(en_q)
);

// File: tb/chan_evt_flags_tb.sv
module chan_evt_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovf_strobe = 0, cap_strobe = 0, cmp_strobe = 0, mode_capture = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0, cap_value = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;

  int n_checks = 0;
  int n_errors = 0;
  string tag = "R1";

  // bench model
  logic m_ovf = 0, m_ch = 0, m_rc = 0, m_irq = 0;
  logic [1:0] m_en = '0;
  logic [DW-1:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_evt_flags #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ovf_strobe(ovf_strobe), .cap_strobe(cap_strobe),
    .cmp_strobe(cmp_strobe), .mode_capture(mode_capture), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .cap_value(cap_value), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [DW-1:0] read_model(input logic [AW-1:0] a, input logic [DW-1:0] cv);
    logic [DW-1:0] w = '0;
    case (a)
      2'd0: w[1:0] = m_en;
      2'd1: begin w[0] = m_ovf; w[1] = m_ch; w[9] = m_rc; end
      2'd3: w = cv;
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // one clock cycle, starting and ending at a falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic ovs, input logic cps,
                     input logic cms, input logic md, input logic [DW-1:0] cv);
    logic sw, trig, ovf_e, ch_e, rc_e, n_ovf, n_ch, n_rc;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    ovf_strobe = ovs; cap_strobe = cps; cmp_strobe = cms;
    mode_capture = md; cap_value = cv;
    sw    = wr && a == 2'd1;
    trig  = wr && a == 2'd2;
    ovf_e = ovs | (trig & wd[0]);
    ch_e  = (md ? cps : cms) | (trig & wd[1]);
    rc_e  = md & ch_e & m_ch;
    n_ovf = ovf_e | (m_ovf & !(sw & !wd[0]));
    n_ch  = ch_e | (m_ch & !(sw & !wd[1]) & !(md & rd & a == 2'd3));
    n_rc  = rc_e | (m_rc & !(sw & !wd[9]));
    if (rd) m_rdata = read_model(a, cv);
    m_irq = (m_ovf & m_en[0]) | (m_ch & m_en[1]);
    if (wr && a == 2'd0) m_en = wd[1:0];
    m_ovf = n_ovf; m_ch = n_ch; m_rc = n_rc;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ovf_strobe = 0; cap_strobe = 0; cmp_strobe = 0;
    check("R11 irq", {15'd0, irq}, {15'd0, m_irq});
    if (rd) check($sformatf("%s rdata addr %0d", tag, a), bus_rdata, m_rdata);
  endtask

  task automatic idle(input logic md);
    cyc(0, 0, 0, 0, 0, 0, 0, md, 0);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic md);
    cyc(0, 1, a, 0, 0, 0, 0, md, 16'hBEEF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    int unsigned seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    tag = "R12"; rd_reg(1, 0); rd_reg(0, 0); idle(0);
    // R8 enables readback
    tag = "R8"; cyc(1, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0); rd_reg(0, 0);
    cyc(1, 0, 0, 16'h0000, 0, 0, 0, 0, 0);
    // R7 overflow, R2 write-1 keeps, write-0 clears
    tag = "R7"; cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); rd_reg(1, 0);
    tag = "R2"; cyc(1, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0); rd_reg(1, 0);
    cyc(1, 0, 1, 16'hFFFE, 0, 0, 0, 0, 0); rd_reg(1, 0);
    // R3: compare ignored in input mode, capture sets
    tag = "R3"; cyc(0, 0, 0, 0, 0, 0, 1, 1, 0); rd_reg(1, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0); rd_reg(1, 1);
    // R6 recapture
    tag = "R6"; cyc(0, 0, 0, 0, 0, 1, 0, 1, 0); rd_reg(1, 1);
    // R5 cap read clears ch and returns value; recapture stays
    tag = "R5"; cyc(0, 1, 3, 0, 0, 0, 0, 1, 16'h1234); rd_reg(1, 1);
    tag = "R6"; cyc(1, 0, 1, 16'hFDFF, 0, 0, 0, 1, 0); rd_reg(1, 1);
    // R4 output mode: capture ignored, compare sets, cap read keeps
    tag = "R4"; cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); rd_reg(1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); cyc(0, 1, 3, 0, 0, 0, 0, 0, 16'h5A5A);
    rd_reg(1, 0); cyc(1, 0, 1, 16'h0000, 0, 0, 0, 0, 0);
    // R9 trigger: zeros do nothing, ones raise events, reads 0
    tag = "R9"; cyc(1, 0, 2, 16'h0000, 0, 0, 0, 1, 0); rd_reg(1, 1);
    cyc(1, 0, 2, 16'h0003, 0, 0, 0, 1, 0); rd_reg(1, 1);
    cyc(1, 0, 2, 16'h0002, 0, 0, 0, 1, 0); rd_reg(1, 1); rd_reg(2, 1);
    // R10 set beats clear
    tag = "R10"; cyc(1, 0, 1, 16'h0000, 1, 1, 0, 1, 0); rd_reg(1, 1);
    // R11 irq with enables
    tag = "R11"; cyc(1, 0, 0, 16'h0003, 0, 0, 0, 1, 0); idle(1); idle(1);
    cyc(1, 0, 1, 16'h0000, 0, 0, 0, 1, 0); idle(1); idle(1);
    // random mix
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [DW-1:0] wd = (r[3:0] < 4) ? 16'h0000 : ((r[3:0] < 8) ? 16'hFFFF : r[31:16]);
      cyc(r[4] & r[5], r[6] | r[7], r[9:8], wd, r[10] & r[11], r[12] & r[13],
          r[14] & r[15], r[17] | r[18] | r[19], 16'(r * 7));
    end
    // R12 reset mid-run
    tag = "R12";
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_ovf = 0; m_ch = 0; m_rc = 0; m_en = '0; m_rdata = '0; m_irq = 0;
    check("R12 irq after reset", {15'd0, irq}, 16'd0);
    check("R12 rdata after reset", bus_rdata, 16'd0);
    rd_reg(1, 0); rd_reg(0, 0);
    if (seed == 32'hFFFF_FFFF) $display("seed");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule